// File: doc/BRIEF.md
# Debug Port Lock Controller

This block decides, after every brown-out reset, how much access a debug probe and a serial bootloader get to the chip. It walks a short list of protection words held in nonvolatile memory through a 16-bit word-read port: a 32-bit debug signature, a 32-bit bootloader signature, up to four stored debug password words and one configuration word. From these it derives whether the debug port is open, shut, or shut behind a password, and whether the bootloader is skipped at start-up.

When the port is shut behind a password, a debugger presents 16-bit words on a simple valid/word interface. The block compares them against the stored words and reports one pass or one fail pulse after the last word. A pass opens the debug port until the next brown-out reset. A bootloader session that has already proven the device password may ask for the debug signature to be wiped back to the all-ones value. The block then writes the two signature halves and reports completion. The new value takes effect at the next reset.

Top module: `dbg_lock_ctrl`

## Requirements
- R1: From reset release until the last protection word is captured, `busy` is high and `dbg_enable`, `dbg_pw_mode` and `boot_bypass` are all low.
- R2: The reset sequence issues exactly nine word reads, at FF80h, FF82h, FF84h, FF86h, FF88h, FF8Ah, FF8Ch, FF8Eh and FF90h, in that order. The lower address of each pair holds the low half of a 32-bit value.
- R3: A debug signature {FF82h,FF80h} equal to FFFF_FFFFh or 0000_0000h gives `dbg_enable`=1. Any other value gives `dbg_enable`=0 until a password is accepted.
- R4: `boot_bypass` is 1 exactly when the bootloader signature {FF86h,FF84h} equals 5555_5555h.
- R5: The configuration word at FF90h selects password mode with bit 15 and the password length minus one with bits [1:0]. `dbg_pw_mode` is 1 only when the debug signature locks the port and bit 15 is set.
- R6: In password mode, presenting the stored words from FF88h upward, one per `pw_vld` cycle and as many as the length field gives, raises `pw_ok` for one cycle after the last word and sets `dbg_enable`.
- R7: If any presented word differs from the stored word, no pulse appears before the last word. After the last word `pw_fail` pulses for one cycle and `dbg_enable` stays 0. The next attempt starts from the first word again.
- R8: Once a password is accepted, `dbg_enable` stays 1 whatever words follow, until the next brown-out reset brings back the locked evaluation.
- R9: Words presented while not in password mode, or while `busy`, produce no pulse and do not change `dbg_enable`.
- R10: A `clr_req` with `bl_auth`=1 and `bl_disabled`=0, while not busy, writes FFFFh to FF80h and then FFFFh to FF82h, and pulses `clr_done` for one cycle after the second write. The status outputs do not change until the next reset, after which the port is open.
- R11: A `clr_req` with `bl_auth`=0 or `bl_disabled`=1 writes nothing and gives no `clr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bor_n | input | 1 | Active-low brown-out reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (with `mem_req`) |
| mem_addr | output | 16 | Memory byte address, word aligned |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| pw_vld | input | 1 | Debugger password word valid |
| pw_word | input | 16 | Debugger password word |
| pw_ok | output | 1 | One-cycle pulse: password accepted |
| pw_fail | output | 1 | One-cycle pulse: password rejected |
| bl_disabled | input | 1 | Bootloader disabled |
| bl_auth | input | 1 | Bootloader session has verified the device password |
| clr_req | input | 1 | Request to wipe the debug signature |
| clr_done | output | 1 | One-cycle pulse: signature wipe written |
| busy | output | 1 | Reset-time read sequence in progress |
| dbg_enable | output | 1 | Debug port access granted |
| dbg_pw_mode | output | 1 | Debug port locked behind a password |
| boot_bypass | output | 1 | Bootloader skipped at start-up |

## Verification
On every cycle the assertions check that the port stays shut while busy, and that pass and fail pulses come only after a presented word. They also check that a granted unlock never drops before reset, that `clr_done` follows the write to the upper signature half, and that status outputs hold still once the read sequence ends. The read order and the decode of each signature value can only be shown by the bench's scenarios. So can the outcome of a correct or a wrong password of each length, and the unlocked state reached after a wipe and a fresh reset.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
    localparam int WORD_W = 16;

    localparam logic [31:0] SIG_ALL_ONES  = 32'hFFFF_FFFF;
    localparam logic [31:0] SIG_ALL_ZEROS = 32'h0000_0000;
    localparam logic [31:0] BOOT_SKIP_VAL = 32'h5555_5555;
    localparam logic [15:0] WIPE_WORD     = 16'hFFFF;
    localparam int          CFG_EN_BIT    = 15;

    typedef enum logic [1:0] {
        F_READ,
        F_WIPE_LO,
        F_WIPE_HI,
        F_IDLE
    } fetch_st_e;
endpackage

// File: rtl/dlc_fetch.sv
module dlc_fetch
    import dlc_pkg::*;
#(
    parameter int                AW       = 16,
    parameter int                DW       = 16,
    parameter int                NREAD    = 9,
    parameter logic [AW-1:0]     SIG_BASE = 16'hFF80
) (
    input  logic                       clk,
    input  logic                       bor_n,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [AW-1:0]              mem_addr,
    output logic [DW-1:0]              mem_wdata,
    input  logic [DW-1:0]              mem_rdata,
    input  logic                       wipe_go,
    output logic                       wipe_done,
    output logic                       busy,
    output logic [NREAD-1:0][DW-1:0]   words
);
    localparam int IW = $clog2(NREAD + 1);

    typedef struct packed {
        fetch_st_e                 st;
        logic [IW-1:0]             rd_idx;
        logic                      cap_vld;
        logic [IW-1:0]             cap_idx;
        logic [NREAD-1:0][DW-1:0]  words;
        logic                      done;
    } fetch_t;

    fetch_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.cap_vld = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = SIG_BASE;
        mem_wdata = WIPE_WORD;
        if (s_q.cap_vld) begin
            s_d.words[s_q.cap_idx] = mem_rdata;
        end
        unique case (s_q.st)
            F_READ: begin
                if (s_q.rd_idx < IW'(NREAD)) begin
                    mem_req     = 1'b1;
                    mem_addr    = SIG_BASE + AW'(2 * s_q.rd_idx);
                    s_d.cap_vld = 1'b1;
                    s_d.cap_idx = s_q.rd_idx;
                    s_d.rd_idx  = s_q.rd_idx + 1'b1;
                end else if (!s_q.cap_vld) begin
                    s_d.st = F_IDLE;
                end
            end
            F_WIPE_LO: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = SIG_BASE;
                s_d.st   = F_WIPE_HI;
            end
            F_WIPE_HI: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = SIG_BASE + AW'(2);
                s_d.st   = F_IDLE;
                s_d.done = 1'b1;
            end
            default: begin
                if (wipe_go) s_d.st = F_WIPE_LO;
            end
        endcase
    end

    always_ff @(posedge clk or negedge bor_n) begin
        if (!bor_n) begin
            s_q <= '{st: F_READ, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st == F_READ);
    assign words     = s_q.words;
    assign wipe_done = s_q.done;

    p_done_after_hi_write_r10: assert property (@(posedge clk) disable iff (!bor_n)
        wipe_done |-> ($past(mem_we) && $past(mem_addr) == SIG_BASE + AW'(2)));

    p_no_write_during_reads_r11: assert property (@(posedge clk) disable iff (!bor_n)
        busy |-> !mem_we);
endmodule

// File: rtl/dlc_decode.sv
module dlc_decode
    import dlc_pkg::*;
#(
    parameter int DW    = 16,
    parameter int IDX_W = 2
) (
    input  logic [DW-1:0]    sig_lo,
    input  logic [DW-1:0]    sig_hi,
    input  logic [DW-1:0]    boot_lo,
    input  logic [DW-1:0]    boot_hi,
    input  logic [DW-1:0]    cfg,
    output logic             sig_open,
    output logic             boot_skip,
    output logic             pw_en,
    output logic [IDX_W-1:0] len_m1
);
    logic [31:0] sig_w, boot_w;

    always_comb begin
        sig_w     = {sig_hi, sig_lo};
        boot_w    = {boot_hi, boot_lo};
        sig_open  = (sig_w == SIG_ALL_ONES) || (sig_w == SIG_ALL_ZEROS);
        boot_skip = (boot_w == BOOT_SKIP_VAL);
        pw_en     = cfg[CFG_EN_BIT];
        len_m1    = cfg[IDX_W-1:0];
    end
endmodule

// File: rtl/dlc_pw_cmp.sv
module dlc_pw_cmp #(
    parameter int DW     = 16,
    parameter int MAX_PW = 4,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      bor_n,
    input  logic                      armed,
    input  logic                      pw_vld,
    input  logic [DW-1:0]             pw_word,
    input  logic [MAX_PW-1:0][DW-1:0] stored,
    input  logic [IDX_W-1:0]          len_m1,
    output logic                      granted,
    output logic                      ok,
    output logic                      fail
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             mis;
        logic             granted;
        logic             ok;
        logic             fail;
    } cmp_t;

    cmp_t c_d, c_q;

    always_comb begin
        logic mis_next;
        c_d      = c_q;
        c_d.ok   = 1'b0;
        c_d.fail = 1'b0;
        mis_next = c_q.mis | (pw_word != stored[c_q.idx]);
        if (!armed || c_q.granted) begin
            c_d.idx = '0;
            c_d.mis = 1'b0;
        end else if (pw_vld) begin
            if (c_q.idx == len_m1) begin
                c_d.idx = '0;
                c_d.mis = 1'b0;
                if (mis_next) begin
                    c_d.fail = 1'b1;
                end else begin
                    c_d.ok      = 1'b1;
                    c_d.granted = 1'b1;
                end
            end else begin
                c_d.idx = c_q.idx + 1'b1;
                c_d.mis = mis_next;
            end
        end
    end

    always_ff @(posedge clk or negedge bor_n) begin
        if (!bor_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign granted = c_q.granted;
    assign ok      = c_q.ok;
    assign fail    = c_q.fail;

    p_pulse_after_word_r6: assert property (@(posedge clk) disable iff (!bor_n)
        (ok || fail) |-> $past(pw_vld));

    p_fail_keeps_locked_r7: assert property (@(posedge clk) disable iff (!bor_n)
        fail |-> !granted);

    p_grant_sticky_r8: assert property (@(posedge clk) disable iff (!bor_n)
        granted |=> granted);
endmodule

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl
    import dlc_pkg::*;
#(
    parameter int            AW       = 16,
    parameter int            MAX_PW   = 4,
    parameter logic [AW-1:0] SIG_BASE = 16'hFF80
) (
    input  logic                clk,
    input  logic                bor_n,
    output logic                mem_req,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                pw_vld,
    input  logic [WORD_W-1:0]   pw_word,
    output logic                pw_ok,
    output logic                pw_fail,
    input  logic                bl_disabled,
    input  logic                bl_auth,
    input  logic                clr_req,
    output logic                clr_done,
    output logic                busy,
    output logic                dbg_enable,
    output logic                dbg_pw_mode,
    output logic                boot_bypass
);
    localparam int IDX_W   = (MAX_PW > 1) ? $clog2(MAX_PW) : 1;
    localparam int PW_BASE = 4;
    localparam int CFG_IDX = PW_BASE + MAX_PW;
    localparam int NREAD   = CFG_IDX + 1;

    logic [NREAD-1:0][WORD_W-1:0]  words;
    logic [MAX_PW-1:0][WORD_W-1:0] stored;
    logic                          sig_open, boot_skip, pw_en, granted, armed, wipe_go;
    logic [IDX_W-1:0]              len_m1;

    assign wipe_go = clr_req && bl_auth && !bl_disabled;

    dlc_fetch #(.AW(AW), .DW(WORD_W), .NREAD(NREAD), .SIG_BASE(SIG_BASE)) u_fetch (
        .clk       (clk),
        .bor_n     (bor_n),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .wipe_go   (wipe_go),
        .wipe_done (clr_done),
        .busy      (busy),
        .words     (words)
    );

    for (genvar g = 0; g < MAX_PW; g++) begin : g_pw
        assign stored[g] = words[PW_BASE + g];
    end

    dlc_decode #(.DW(WORD_W), .IDX_W(IDX_W)) u_decode (
        .sig_lo    (words[0]),
        .sig_hi    (words[1]),
        .boot_lo   (words[2]),
        .boot_hi   (words[3]),
        .cfg       (words[CFG_IDX]),
        .sig_open  (sig_open),
        .boot_skip (boot_skip),
        .pw_en     (pw_en),
        .len_m1    (len_m1)
    );

    assign armed = !busy && !sig_open && pw_en;

    dlc_pw_cmp #(.DW(WORD_W), .MAX_PW(MAX_PW), .IDX_W(IDX_W)) u_cmp (
        .clk     (clk),
        .bor_n   (bor_n),
        .armed   (armed),
        .pw_vld  (pw_vld),
        .pw_word (pw_word),
        .stored  (stored),
        .len_m1  (len_m1),
        .granted (granted),
        .ok      (pw_ok),
        .fail    (pw_fail)
    );

    assign dbg_enable  = !busy && (sig_open || granted);
    assign dbg_pw_mode = armed;
    assign boot_bypass = !busy && boot_skip;

    p_closed_while_busy_r1: assert property (@(posedge clk) disable iff (!bor_n)
        busy |-> (!dbg_enable && !dbg_pw_mode && !boot_bypass));

    p_status_frozen_r10: assert property (@(posedge clk) disable iff (!bor_n)
        (!busy && !$past(busy)) |-> ($stable(dbg_pw_mode) && $stable(boot_bypass)));
endmodule

// File: tb/dbg_lock_ctrl_bench.sv
module dbg_lock_ctrl_bench;
    logic        clk = 1'b0;
    logic        bor_n = 1'b0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        pw_vld = 1'b0;
    logic [15:0] pw_word = '0;
    logic        pw_ok, pw_fail;
    logic        bl_disabled = 1'b0, bl_auth = 1'b0, clr_req = 1'b0;
    logic        clr_done, busy, dbg_enable, dbg_pw_mode, boot_bypass;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] mem_arr [0:63];
    logic [15:0] rd_log [0:15];
    int          rd_cnt = 0;
    int          wr_cnt = 0;

    always #2.5 clk = ~clk;

    dbg_lock_ctrl u_dbg_lock_ctrl (
        .clk(clk), .bor_n(bor_n),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pw_vld(pw_vld), .pw_word(pw_word), .pw_ok(pw_ok), .pw_fail(pw_fail),
        .bl_disabled(bl_disabled), .bl_auth(bl_auth), .clr_req(clr_req),
        .clr_done(clr_done), .busy(busy), .dbg_enable(dbg_enable),
        .dbg_pw_mode(dbg_pw_mode), .boot_bypass(boot_bypass)
    );

    always @(posedge clk) begin
        if (!bor_n) begin
            rd_cnt <= 0;
        end else if (mem_req) begin
            if (mem_we) begin
                mem_arr[mem_addr[6:1]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem_arr[mem_addr[6:1]];
                if (rd_cnt < 16) rd_log[rd_cnt] <= mem_addr;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [31:0] sig, input logic [31:0] bsig, input logic [15:0] cfg,
                        input logic [15:0] p0, input logic [15:0] p1,
                        input logic [15:0] p2, input logic [15:0] p3);
        for (int i = 0; i < 64; i++) mem_arr[i] = 16'h0BAD;
        mem_arr[0] = sig[15:0];  mem_arr[1] = sig[31:16];
        mem_arr[2] = bsig[15:0]; mem_arr[3] = bsig[31:16];
        mem_arr[4] = p0; mem_arr[5] = p1; mem_arr[6] = p2; mem_arr[7] = p3;
        mem_arr[8] = cfg;
    endtask

    task automatic do_reset();
        @(negedge clk);
        bor_n = 1'b0;
        repeat (2) @(negedge clk);
        bor_n = 1'b1;
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 40 && busy; i++) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, output logic ok, output logic fl);
        pw_word = w;
        pw_vld  = 1'b1;
        @(negedge clk);
        pw_vld  = 1'b0;
        ok = pw_ok;
        fl = pw_fail;
    endtask

    task automatic t_reset_state();
        load(32'hFFFF_FFFF, 32'h5555_5555, 16'h8003, 1, 2, 3, 4);
        do_reset();
        chk("R1 busy after release", busy, 1);
        chk("R1 enable closed while busy", dbg_enable, 0);
        chk("R1 bypass low while busy", boot_bypass, 0);
        @(negedge clk);
        chk("R1 still closed", dbg_enable, 0);
        wait_ready();
        chk("R1 busy cleared", busy, 0);
        chk("R2 read count", rd_cnt, 9);
        for (int i = 0; i < 9; i++)
            chk("R2 read address order", rd_log[i], 32'hFF80 + 2 * i);
        chk("R3 all-ones signature opens", dbg_enable, 1);
        chk("R4 skip signature bypasses", boot_bypass, 1);
        chk("R5 open signature not pw mode", dbg_pw_mode, 0);
    endtask

    task automatic t_open_zeros();
        logic ok, fl;
        load(32'h0000_0000, 32'h5555_5554, 16'h8000, 16'h1111, 0, 0, 0);
        do_reset();
        wait_ready();
        chk("R3 all-zero signature opens", dbg_enable, 1);
        chk("R4 near-miss boot value no bypass", boot_bypass, 0);
        send(16'h1111, ok, fl);
        chk("R9 no pulse when open", {ok, fl}, 0);
        chk("R9 still open", dbg_enable, 1);
    endtask

    task automatic t_locked_nopw();
        logic ok, fl;
        load(32'h1234_5678, 32'h0000_0000, 16'h0000, 16'hAAAA, 0, 0, 0);
        do_reset();
        wait_ready();
        chk("R3 other signature locks", dbg_enable, 0);
        chk("R5 cfg bit15 clear no pw mode", dbg_pw_mode, 0);
        send(16'hAAAA, ok, fl);
        chk("R9 words ignored without pw mode", {ok, fl}, 0);
        chk("R9 stays locked", dbg_enable, 0);
    endtask

    task automatic t_pw_good(input int n);
        logic ok, fl;
        logic [15:0] pw [4];
        pw[0] = 16'hC0DE; pw[1] = 16'h1357; pw[2] = 16'hBEEF; pw[3] = 16'h2468;
        load(32'hFFFF_FFFE, 32'h1234_0000, 16'h8000 | 16'(n - 1), pw[0], pw[1], pw[2], pw[3]);
        do_reset();
        send(pw[0], ok, fl);
        chk("R9 word during busy ignored", {ok, fl}, 0);
        wait_ready();
        chk("R5 pw mode on", dbg_pw_mode, 1);
        chk("R6 locked before pw", dbg_enable, 0);
        for (int i = 0; i < n; i++) begin
            send(pw[i], ok, fl);
            if (i < n - 1) chk("R7 no pulse before last word", {ok, fl}, 0);
        end
        chk("R6 ok pulse after last word", {ok, fl}, 2'b10);
        chk("R6 port opened", dbg_enable, 1);
        @(negedge clk);
        chk("R6 ok is one cycle", pw_ok, 0);
        send(16'h0000, ok, fl);
        send(16'h0000, ok, fl);
        chk("R8 grant holds after junk", dbg_enable, 1);
        do_reset();
        wait_ready();
        chk("R8 brown-out relocks", dbg_enable, 0);
    endtask

    task automatic t_pw_bad();
        logic ok, fl;
        load(32'hABCD_0001, 32'h0, 16'h8002, 16'h0101, 16'h0202, 16'h0303, 16'h0404);
        do_reset();
        wait_ready();
        send(16'h0101, ok, fl);
        chk("R7 no pulse word1", {ok, fl}, 0);
        send(16'h0F02, ok, fl);
        chk("R7 no early fail on wrong word", {ok, fl}, 0);
        send(16'h0303, ok, fl);
        chk("R7 fail after last word", {ok, fl}, 2'b01);
        chk("R7 stays locked", dbg_enable, 0);
        send(16'h0101, ok, fl);
        send(16'h0202, ok, fl);
        send(16'h0303, ok, fl);
        chk("R7 retry from first word ok", {ok, fl}, 2'b10);
    endtask

    task automatic t_clear_denied(input logic auth, input logic dis);
        int w0;
        logic seen;
        load(32'h0000_00A5, 32'h0, 16'h0000, 0, 0, 0, 0);
        do_reset();
        wait_ready();
        w0 = wr_cnt;
        seen = 0;
        bl_auth = auth; bl_disabled = dis; clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (clr_done) seen = 1;
            @(negedge clk);
        end
        chk("R11 no done when denied", seen, 0);
        chk("R11 no writes when denied", wr_cnt - w0, 0);
        chk("R11 signature untouched", mem_arr[0], 16'h00A5);
        bl_auth = 0; bl_disabled = 0;
    endtask

    task automatic t_clear_ok();
        int w0, done_cnt;
        load(32'h0000_00A5, 32'h0, 16'h0000, 0, 0, 0, 0);
        do_reset();
        wait_ready();
        chk("R10 locked before wipe", dbg_enable, 0);
        w0 = wr_cnt;
        done_cnt = 0;
        bl_auth = 1; bl_disabled = 0; clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (clr_done) done_cnt++;
            @(negedge clk);
        end
        bl_auth = 0;
        chk("R10 one done pulse", done_cnt, 1);
        chk("R10 two writes", wr_cnt - w0, 2);
        chk("R10 low half wiped", mem_arr[0], 16'hFFFF);
        chk("R10 high half wiped", mem_arr[1], 16'hFFFF);
        chk("R10 status unchanged before reset", dbg_enable, 0);
        do_reset();
        wait_ready();
        chk("R10 open after reset", dbg_enable, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        t_open_zeros();
        t_locked_nopw();
        for (int n = 1; n <= 4; n++) t_pw_good(n);
        t_pw_bad();
        t_clear_denied(1'b0, 1'b0);
        t_clear_denied(1'b1, 1'b1);
        t_clear_ok();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule